// File: doc/BRIEF.md
# I2C Slave Transmitter with Software-Paced Flags

This block is the target side of a two-wire serial bus. After a start condition it shifts in the first frame, checks the upper seven bits against an address held on an input port, and answers a match by driving the acknowledge slot to a level chosen by software. When the read/write bit of that frame asks for a read, the block puts itself into transmit mode with no help from software. It then sends data bytes, most significant bit first, from a one-byte holding register.

Software runs the transfer through a small register file. A data-empty flag asks for the next byte, and an end flag reports a byte that finished with nothing queued behind it. The block stretches the clock line low whenever it needs software. While it is stretching, the clock is freed only by loading a byte, or by clearing the transmit mode bit and then reading the receive register. Both bus lines are open-drain: each comes in as a sampled level and goes out as an enable that pulls the line low.

Top module: `i2cs_slave_tx`

## Requirements
- R1: After reset every register reads 0 and neither line is pulled. While enable (control register, address 0, bit 0) is 0 the block pulls neither line whatever the bus does. Writing enable as 0 also clears the mode bit and both flags.
- R2: The first eight bits after a start condition are taken MSB first and stored into the receive register (address 3) at the falling SCL edge that ends the eighth bit, whether or not they match.
- R3: When bits 7..1 of that first frame equal the own address, SDA carries the acknowledge level (control bit 2: 0 pulls low, 1 releases) from the eighth SCL falling edge to the ninth. Otherwise, and for every later frame before the next start, SDA is not pulled.
- R4: When a matched frame has bit 0 set, the mode bit (control bit 1) and the data-empty flag (status register, address 1, bit 0) are set, and SCL is held low from the ninth falling edge until a byte is available.
- R5: Data bytes go out MSB first, and SDA is only changed while SCL is low.
- R6: Writing the transmit register (address 2) clears data-empty. Moving that byte into the shifter sets data-empty again and frees SCL. A byte written before the acknowledge slot ends follows the previous one with no stretch.
- R7: SDA is released in each ninth clock and the master's bit is taken on its rising edge. If the master acknowledged and no byte is waiting, the end flag (status bit 1) is set and SCL is held low.
- R8: After a not-acknowledge, no further byte is sent, even if one is waiting, and SCL is held low.
- R9: While SCL is held, it is freed only when the mode bit is 0 and the receive register is read. A read with the mode bit at 1 leaves it held. Software cannot set the mode bit.
- R10: Writing 0 to a status bit clears that flag, and writing 1 leaves it as it was.
- R11: A repeated start restarts the address comparison, and a stop returns the block to idle with both lines released.
- R12: A matched frame with bit 0 clear is acknowledged, leaves the mode bit at 0, and is followed by no further drive on SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at address 3) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit, 3 receive |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |

## Verification
The checker watches a few rules on every cycle. SDA may only move while the synchronized clock is low, apart from start, stop and disable. A held clock is freed only by a byte load or by the release sequence, and a load always frees it. Entering transmit mode always raises data-empty, and a disabled block stays off the bus. The bench scenarios are what show the bytes on the wire and the acknowledge levels. They also cover the flag values after each step, the block ignoring frames after the first, the clock held through a not-acknowledge with a byte still pending, and the two-step release.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_STALL,
    ST_TX,
    ST_TACK,
    ST_SKIP
  } eng_state_e;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd1;
  localparam logic [REG_AW-1:0] RA_TXD  = 2'd2;
  localparam logic [REG_AW-1:0] RA_RXD  = 2'd3;

  // Open-drain: to show a level on the wire, pull low only for a 0.
  function automatic logic pull_for(input logic level);
    return !level;
  endfunction

  // Address part of a frame sits above the direction bit.
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe    <= '1;
        prev[g] <= 1'b1;
      end else begin
        pipe    <= {pipe[SYNC_STAGES-2:0], raw[g]};
        prev[g] <= pipe[SYNC_STAGES-1];
      end
    end
    assign synced[g] = pipe[SYNC_STAGES-1];
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] && !prev[0];
  assign scl_fall  = !synced[0] && prev[0];
  assign start_det = synced[0] && prev[0] && prev[1] && !synced[1];
  assign stop_det  = synced[0] && prev[0] && !prev[1] && synced[1];

endmodule

// File: rtl/i2cs_host_regs.sv
module i2cs_host_regs
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_set_tx,
  input  logic              ev_load,
  input  logic              ev_tend,
  input  logic              ev_addr,
  input  logic [DATA_W-1:0] addr_frame,
  output logic              en,
  output logic              trs,
  output logic              ack_lvl,
  output logic              tde,
  output logic              tend,
  output logic [DATA_W-1:0] txd,
  output logic              rx_read
);
  logic [DATA_W-1:0] rxd;
  logic              wr_ctrl, wr_stat, wr_txd;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_txd  = reg_wr && (reg_addr == RA_TXD);
  assign rx_read = reg_rd && (reg_addr == RA_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      trs     <= 1'b0;
      ack_lvl <= 1'b0;
      tde     <= 1'b0;
      tend    <= 1'b0;
      txd     <= '0;
      rxd     <= '0;
    end else begin
      if (wr_ctrl) begin
        en      <= reg_wdata[0];
        ack_lvl <= reg_wdata[2];
        trs     <= trs && reg_wdata[1] && reg_wdata[0];
        if (!reg_wdata[0]) begin
          tde  <= 1'b0;
          tend <= 1'b0;
        end
      end
      if (wr_stat) begin
        tde  <= tde && reg_wdata[0];
        tend <= tend && reg_wdata[1];
      end
      if (wr_txd) txd <= reg_wdata;
      if (ev_load) tde <= 1'b1;
      if (wr_txd) tde <= 1'b0;
      if (ev_tend) tend <= 1'b1;
      if (ev_set_tx) begin
        trs <= 1'b1;
        tde <= 1'b1;
      end
      if (ev_addr) rxd <= addr_frame;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[2:0] = {ack_lvl, trs, en};
      RA_STAT: reg_rdata[1:0] = {tend, tde};
      RA_TXD:  reg_rdata      = txd;
      default: reg_rdata      = rxd;
    endcase
  end

endmodule

// File: rtl/i2cs_xfer_engine.sv
module i2cs_xfer_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              en,
  input  logic              trs,
  input  logic              ack_lvl,
  input  logic              tde,
  input  logic [DATA_W-1:0] txd,
  input  logic              rx_read,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ev_addr,
  output logic              ev_set_tx,
  output logic              ev_load,
  output logic              ev_tend,
  output logic [DATA_W-1:0] addr_frame
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  eng_state_e        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              sda_drv, sda_n;
  logic              scl_hold, scl_n;
  logic              nacked, nack_n;
  logic              do_load;

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    sh_n      = sh;
    sda_n     = sda_drv;
    scl_n     = scl_hold;
    nack_n    = nacked;
    ev_addr   = 1'b0;
    ev_set_tx = 1'b0;
    ev_tend   = 1'b0;
    do_load   = 1'b0;
    if (!en) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      sda_n = 1'b0;
      scl_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      sda_n = 1'b0;
      scl_n = 1'b0;
    end else if (stop_det) begin
      st_n  = ST_IDLE;
      sda_n = 1'b0;
      scl_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh[DATA_W-2:0], sda_s};
            cnt_n = cnt + CNT_W'(1);
          end else if (scl_fall && cnt == LAST_BIT) begin
            ev_addr = 1'b1;
            if (addr_hit(sh, own_addr)) begin
              sda_n = pull_for(ack_lvl);
              st_n  = ST_AACK;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            sda_n = 1'b0;
            if (sh[0]) begin
              ev_set_tx = 1'b1;
              scl_n     = 1'b1;
              nack_n    = 1'b0;
              st_n      = ST_STALL;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        ST_STALL: begin
          if (trs && !nacked && !tde) begin
            do_load = 1'b1;
          end else if (!trs && rx_read) begin
            scl_n = 1'b0;
            st_n  = ST_SKIP;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_n = 1'b0;
              st_n  = ST_TACK;
            end else begin
              sda_n = pull_for(sh[DATA_W-2]);
              sh_n  = sh << 1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            if (!nacked && !tde && trs) begin
              do_load = 1'b1;
            end else begin
              ev_tend = tde;
              scl_n   = 1'b1;
              st_n    = ST_STALL;
            end
          end
        end
        default: ;
      endcase
    end
    ev_load = do_load;
    if (do_load) begin
      sh_n  = txd;
      sda_n = pull_for(txd[DATA_W-1]);
      scl_n = 1'b0;
      cnt_n = '0;
      st_n  = ST_TX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_drv  <= 1'b0;
      scl_hold <= 1'b0;
      nacked   <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      sh       <= sh_n;
      sda_drv  <= sda_n;
      scl_hold <= scl_n;
      nacked   <= nack_n;
    end
  end

  assign scl_oe     = scl_hold;
  assign sda_oe     = sda_drv;
  assign addr_frame = sh;

endmodule

// File: rtl/i2cs_slave_tx.sv
module i2cs_slave_tx
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ctl_en, ctl_trs, ctl_ack, flag_tde, flag_tend, rx_read;
  logic ev_addr, ev_set_tx, ev_load, ev_tend;
  logic [DATA_W-1:0] txd, addr_frame;

  i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_set_tx(ev_set_tx), .ev_load(ev_load), .ev_tend(ev_tend),
    .ev_addr(ev_addr), .addr_frame(addr_frame),
    .en(ctl_en), .trs(ctl_trs), .ack_lvl(ctl_ack), .tde(flag_tde),
    .tend(flag_tend), .txd(txd), .rx_read(rx_read)
  );

  i2cs_xfer_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .en(ctl_en), .trs(ctl_trs), .ack_lvl(ctl_ack), .tde(flag_tde),
    .txd(txd), .rx_read(rx_read), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ev_addr(ev_addr), .ev_set_tx(ev_set_tx), .ev_load(ev_load),
    .ev_tend(ev_tend), .addr_frame(addr_frame)
  );

endmodule

// File: rtl/i2cs_slave_tx_chk.sv
module i2cs_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic trs,
  input logic tde,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic scl_oe,
  input logic sda_oe,
  input logic ev_load,
  input logic rx_read
);

  // R5
  sda_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det || stop_det || !en)) |-> !$past(scl_s));

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));

  // R9
  scl_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(ev_load || (rx_read && !trs) || start_det || stop_det || !en));

  // R4
  tx_entry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trs) |-> tde);

  // R6
  load_frees_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> !scl_oe);

endmodule

bind i2cs_slave_tx i2cs_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .trs(ctl_trs), .tde(flag_tde),
  .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .ev_load(ev_load), .rx_read(rx_read)
);

// File: tb/test_i2cs_slave_tx.sv
module test_i2cs_slave_tx;
  localparam int Q = 12;
  localparam logic [6:0] OWN = 7'h2A;
  // {frame, ack level, expect SDA pulled in ack slot, expect mode bit}
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {8'h54, 1'b0, 1'b1, 1'b0},
    {8'h55, 1'b0, 1'b1, 1'b1},
    {8'h56, 1'b0, 1'b0, 1'b0},
    {8'h55, 1'b1, 1'b0, 1'b1},
    {8'hD5, 1'b0, 1'b0, 1'b0},
    {8'h54, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  int tests = 0, fails = 0, sda_viol = 0;
  logic done = 1'b0;
  logic prev_sda_oe = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2cs_slave_tx i_i2cs_slave_tx (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // R5: watch for SDA drive changes while the clock line is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_sda_oe) && scl_line) sda_viol++;
    prev_sda_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; cyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); cyc(Q);
    m_sda_low = 1'b1; cyc(Q);
    m_scl_low = 1'b1; cyc(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; cyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); cyc(Q);
    m_sda_low = 1'b0; cyc(Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    m_sda_low = !b; cyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); cyc(Q);
    seen = sda_line;
    m_scl_low = 1'b1; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      v[i] = s;
    end
  endtask

  initial begin
    logic [7:0] rd, frame;
    logic s, ackl, exp_pull, exp_trs;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);

    // Reset state (R1)
    host_rd(2'd0, rd); chk("R1 ctrl after reset", rd, 8'h00);
    host_rd(2'd1, rd); chk("R1 status after reset", rd, 8'h00);
    chk("R1 lines free after reset", {scl_oe, sda_oe}, 2'b00);

    // Disabled block ignores a matching read address (R1)
    bus_start(); send_byte(8'h55); clock_bit(1'b1, s);
    chk("R1 no ack while disabled", s, 1'b1);
    cyc(Q); chk("R1 scl free while disabled", scl_oe, 1'b0);
    bus_stop();

    // Software cannot set the mode bit (R9)
    host_wr(2'd0, 8'h03); host_rd(2'd0, rd);
    chk("R9 mode bit not settable", rd, 8'h01);

    // Vector table over address frames (R2 R3 R4 R9 R10 R12)
    for (int v = 0; v < NV; v++) begin
      {frame, ackl, exp_pull, exp_trs} = VEC[v];
      host_wr(2'd0, {5'b0, ackl, 1'b0, 1'b1});
      bus_start(); send_byte(frame); clock_bit(1'b1, s);
      chk($sformatf("R3 ack slot vec%0d", v), s, !exp_pull);
      cyc(Q);
      host_rd(2'd0, rd);
      chk($sformatf("R4 R12 mode bit vec%0d", v), rd[1], exp_trs);
      chk($sformatf("R4 scl held vec%0d", v), scl_oe, exp_trs);
      host_rd(2'd3, rd);
      chk($sformatf("R2 frame captured vec%0d", v), rd, frame);
      if (exp_trs) begin
        host_rd(2'd1, rd); chk($sformatf("R4 data-empty set vec%0d", v), rd, 8'h01);
        cyc(4); chk($sformatf("R9 read with mode 1 keeps hold vec%0d", v), scl_oe, 1'b1);
        host_wr(2'd0, {5'b0, ackl, 1'b0, 1'b1});
        host_rd(2'd3, rd); cyc(4);
        chk($sformatf("R9 release sequence vec%0d", v), scl_oe, 1'b0);
        host_wr(2'd1, 8'h02); host_rd(2'd1, rd);
        chk($sformatf("R10 clear data-empty vec%0d", v), rd, 8'h00);
      end
      bus_stop();
      chk($sformatf("R11 idle after stop vec%0d", v), {scl_oe, sda_oe}, 2'b00);
    end

    // Full read transfer (R5 R6 R7 R8 R9 R10)
    host_wr(2'd0, 8'h01);
    bus_start(); send_byte(8'h55); clock_bit(1'b1, s);
    chk("R3 read ack", s, 1'b0);
    cyc(Q);
    host_rd(2'd1, rd); chk("R4 waiting for byte", rd, 8'h01);
    chk("R4 stretch before first byte", scl_oe, 1'b1);
    host_wr(2'd2, 8'hA5); cyc(4);
    host_rd(2'd1, rd); chk("R6 empty again after load", rd, 8'h01);
    chk("R6 scl freed by load", scl_oe, 1'b0);
    read_byte(rd); chk("R5 first byte", rd, 8'hA5);
    host_wr(2'd2, 8'h3C);
    host_rd(2'd1, rd); chk("R6 write clears empty", rd, 8'h00);
    clock_bit(1'b0, s);
    cyc(Q); chk("R6 back-to-back no stretch", scl_oe, 1'b0);
    read_byte(rd); chk("R6 second byte", rd, 8'h3C);
    clock_bit(1'b0, s);
    cyc(Q);
    chk("R7 stretch when nothing queued", scl_oe, 1'b1);
    host_rd(2'd1, rd); chk("R7 end flag set", rd, 8'h03);
    host_wr(2'd1, 8'h01); host_rd(2'd1, rd);
    chk("R10 clear end flag only", rd, 8'h01);
    host_wr(2'd2, 8'h81); cyc(4);
    read_byte(rd); chk("R5 third byte", rd, 8'h81);
    host_wr(2'd2, 8'h77);
    clock_bit(1'b1, s);
    cyc(Q);
    chk("R8 held after nack", scl_oe, 1'b1);
    host_rd(2'd1, rd); chk("R8 pending byte not taken", rd, 8'h00);
    host_wr(2'd0, 8'h01); cyc(4);
    chk("R9 mode clear alone keeps hold", scl_oe, 1'b1);
    host_rd(2'd3, rd); cyc(4);
    chk("R9 dummy read frees scl", scl_oe, 1'b0);
    bus_stop();

    // Repeated start and first-frame-only compare (R11 R3 R12)
    bus_start(); send_byte(8'h10); clock_bit(1'b1, s);
    chk("R3 mismatch no ack", s, 1'b1);
    bus_start(); send_byte(8'h54); clock_bit(1'b1, s);
    chk("R11 repeated start new compare", s, 1'b0);
    send_byte(8'h55); clock_bit(1'b1, s);
    chk("R12 later frame not acked", s, 1'b1);
    host_rd(2'd0, rd); chk("R12 mode stays receive", rd[1], 1'b0);
    bus_stop();
    chk("R11 idle after stop", {scl_oe, sda_oe}, 2'b00);

    chk("R5 sda only moves with scl low", sda_viol, 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule